// File: doc/BRIEF.md
# Integer Execute Unit with Immediates

This block is the combinational integer execute stage of a 32-bit load/store RISC core. It receives a decoded operation code, the two source register values and the raw 16-bit immediate field of the instruction. In the same cycle it returns the 32-bit value to be written back, plus the effective address for memory operations. The operations are register-register add and subtract, add immediate, load high immediate, shift left logical by an immediate amount, and signed set-less-than. Load and store operations form a base-plus-offset address.

One adder serves several operations. ADD, SUB, ADDI and SLT use it for the write-back value. Loads and stores use it for the address. The register file is outside the block. A source register numbered zero reaches the block as the value 0, so an offset on that base is an absolute address.

Top module: `exu_int`

## Requirements
- R1: With `op_i` = 0 (add), `result_o` is `rs1_i + rs2_i` modulo 2^32. Overflow wraps and raises nothing.
- R2: With `op_i` = 1 (subtract), `result_o` is `rs1_i - rs2_i` modulo 2^32.
- R3: With `op_i` = 2 (add immediate), `result_o` is `rs1_i` plus `imm_i` sign-extended to 32 bits, modulo 2^32.
- R4: With `op_i` = 3 (load high), `result_o` is `{imm_i, 16'h0000}`, whatever the values on `rs1_i` and `rs2_i`.
- R5: With `op_i` = 4 (shift left immediate), `result_o` is `rs1_i` shifted left logically by `imm_i[4:0]`, with zeros shifted in. Bits `imm_i[15:5]` have no effect.
- R6: With `op_i` = 5 (set less than), `result_o` is 1 when `rs1_i` < `rs2_i` as signed two's complement values, and 0 otherwise. This holds across the sign boundary.
- R7: With `op_i` = 6 (load) or 7 (store), `mem_o` is 1 and `ea_o` is `rs1_i` plus the sign-extended `imm_i`, modulo 2^32. `result_o` is 0.
- R8: For `op_i` from 0 to 5, `mem_o` is 0 and `ea_o` is 0.
- R9: A memory operation with `rs1_i` = 0 gives `ea_o` equal to the sign-extended immediate. This is absolute addressing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Decoded operation: 0 add, 1 sub, 2 add imm, 3 load high, 4 shift left imm, 5 set less than, 6 load, 7 store |
| rs1_i | input | 32 | First source operand, also the memory base |
| rs2_i | input | 32 | Second source operand |
| imm_i | input | 16 | Raw immediate field |
| result_o | output | 32 | Write-back value |
| ea_o | output | 32 | Effective address for load/store |
| mem_o | output | 1 | High for load/store operations |

## Verification
Add immediate and address generation use the same adder with the same operand selection. In a core, an ADDI and a load with equal base and offset can therefore meet on this path in one cycle. The bench applies such pairs back to back with identical `rs1_i` and `imm_i`, and requires the ADDI write-back value to match the load's `ea_o` bit for bit. The same pairs also confirm that the address appears only on `ea_o` during the load, while `result_o` stays 0. Signed set-less-than shares the adder in its subtract mode. It is therefore judged both at the sign boundary and on operands whose difference overflows.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned IMM_W = 16;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDI = 3'd2,
    OP_LHI  = 3'd3,
    OP_SLLI = 3'd4,
    OP_SLT  = 3'd5,
    OP_LD   = 3'd6,
    OP_ST   = 3'd7
  } exu_op_e;
endpackage

// File: rtl/exu_imm_ext.sv
module exu_imm_ext #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  sext_o,
  output logic [XLEN-1:0]  high_o
);
  localparam int unsigned PAD_W = XLEN - IMM_W;

  assign sext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
  assign high_o = {imm_i, {PAD_W{1'b0}}};

  always_comb begin
    a_r4_high_low_zero: assert (high_o[PAD_W-1:0] == '0)
      else $error("load-high value has nonzero low bits");
  end
endmodule

// File: rtl/exu_adder.sv
module exu_adder #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_o
);
  logic [XLEN-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
  // signed less-than from the difference; sign mismatch decides directly
  assign lt_o  = (a_i[XLEN-1] ^ b_i[XLEN-1]) ? a_i[XLEN-1] : sum_o[XLEN-1];

  always_comb begin
    a_r6_lt_signed: assert (!sub_i || (lt_o == ($signed(a_i) < $signed(b_i))))
      else $error("signed compare mismatch");
  end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]         val_i,
  input  logic [$clog2(XLEN)-1:0] shamt_i,
  output logic [XLEN-1:0]         val_o
);
  localparam int unsigned SH_W = $clog2(XLEN);

  logic [XLEN-1:0] stg [SH_W+1];

  assign stg[0] = val_i;
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    assign stg[s+1] = shamt_i[s] ? (stg[s] << (1 << s)) : stg[s];
  end
  assign val_o = stg[SH_W];

  always_comb begin
    a_r5_msb_from_src: assert (val_o[XLEN-1] == val_i[XLEN-1-shamt_i])
      else $error("shift output top bit mismatch");
  end
endmodule

// File: rtl/exu_int.sv
module exu_int
  import exu_pkg::*;
(
  input  logic [2:0]       op_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [XLEN-1:0]  rs2_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  result_o,
  output logic [XLEN-1:0]  ea_o,
  output logic             mem_o
);
  localparam int unsigned SH_W = $clog2(XLEN);

  exu_op_e         op;
  logic [XLEN-1:0] imm_sext, imm_high, add_b, sum, shl;
  logic            use_rs2, sub, lt, is_mem;

  assign op = exu_op_e'(op_i);

  exu_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
    .imm_i  (imm_i),
    .sext_o (imm_sext),
    .high_o (imm_high)
  );

  // one adder: reg-reg ops take rs2, immediate and address ops take the offset
  assign use_rs2 = (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT);
  assign sub     = (op == OP_SUB) || (op == OP_SLT);
  assign add_b   = use_rs2 ? rs2_i : imm_sext;

  exu_adder #(.XLEN(XLEN)) u_add (
    .a_i   (rs1_i),
    .b_i   (add_b),
    .sub_i (sub),
    .sum_o (sum),
    .lt_o  (lt)
  );

  exu_shifter #(.XLEN(XLEN)) u_shl (
    .val_i   (rs1_i),
    .shamt_i (imm_i[SH_W-1:0]),
    .val_o   (shl)
  );

  assign is_mem = (op == OP_LD) || (op == OP_ST);
  assign mem_o  = is_mem;
  assign ea_o   = is_mem ? sum : '0;

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDI: result_o = sum;
      OP_LHI:                  result_o = imm_high;
      OP_SLLI:                 result_o = shl;
      OP_SLT:                  result_o = {{(XLEN-1){1'b0}}, lt};
      default:                 result_o = '0;
    endcase
  end

  always_comb begin
    a_r6_slt_boolean: assert (op != OP_SLT || result_o[XLEN-1:1] == '0)
      else $error("set-less-than wider than one bit");
    a_r7_mem_no_wb: assert (!is_mem || result_o == '0)
      else $error("memory op drives write-back");
    a_r7_ea_offset: assert (!mem_o || (ea_o - rs1_i) == imm_sext)
      else $error("effective address offset mismatch");
    a_r8_ea_idle: assert (mem_o || ea_o == '0)
      else $error("address driven on non-memory op");
    a_r4_lhi_top: assert (op != OP_LHI || result_o[XLEN-1 -: IMM_W] == imm_i)
      else $error("load-high top half mismatch");
  end
endmodule

// File: tb/exu_int_bench.sv
module exu_int_bench;
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [31:0] res;
    logic [31:0] ea;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 32'd5,        32'd7,        16'h0000, 32'd12,       32'h0},        // R1
    '{3'd0, 32'hFFFFFFFF, 32'd1,        16'h0000, 32'h0,        32'h0},        // R1 wrap
    '{3'd0, 32'h7FFFFFFF, 32'd1,        16'h0000, 32'h80000000, 32'h0},        // R1 overflow
    '{3'd1, 32'd5,        32'd7,        16'h0000, 32'hFFFFFFFE, 32'h0},        // R2
    '{3'd1, 32'h80000000, 32'd1,        16'h0000, 32'h7FFFFFFF, 32'h0},        // R2 wrap
    '{3'd2, 32'd16,       32'd99,       16'hFFFF, 32'd15,       32'h0},        // R3 neg imm
    '{3'd2, 32'h100,      32'd0,        16'h7FFF, 32'h80FF,     32'h0},        // R3
    '{3'd3, 32'd1234,     32'd5678,     16'h002A, 32'h002A0000, 32'h0},        // R4
    '{3'd4, 32'd3,        32'd0,        16'h0005, 32'h60,       32'h0},        // R5
    '{3'd4, 32'd1,        32'd0,        16'hFFE3, 32'd8,        32'h0},        // R5 upper imm ignored
    '{3'd4, 32'd1,        32'd0,        16'h001F, 32'h80000000, 32'h0},        // R5 max shift
    '{3'd5, 32'd1,        32'd2,        16'h0000, 32'd1,        32'h0},        // R6
    '{3'd5, 32'd2,        32'd1,        16'h0000, 32'd0,        32'h0},        // R6
    '{3'd5, 32'hFFFFFFFF, 32'd1,        16'h0000, 32'd1,        32'h0},        // R6 signed
    '{3'd5, 32'h7FFFFFFF, 32'h80000000, 16'h0000, 32'd0,        32'h0},        // R6 overflowing diff
    '{3'd5, 32'd5,        32'd5,        16'h0000, 32'd0,        32'h0},        // R6 equal
    '{3'd6, 32'h1000,     32'd7,        16'h001E, 32'h0,        32'h101E},     // R7
    '{3'd7, 32'h1000,     32'd7,        16'hFFF0, 32'h0,        32'h0FF0},     // R7 neg offset
    '{3'd6, 32'h0,        32'd0,        16'h03E8, 32'h0,        32'h3E8},      // R9
    '{3'd7, 32'h0,        32'd0,        16'h8000, 32'h0,        32'hFFFF8000}  // R9 sign
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] rs1_i = '0, rs2_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] result_o, ea_o;
  logic        mem_o;
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  exu_int u_exu_int (
    .op_i (op_i), .rs1_i (rs1_i), .rs2_i (rs2_i), .imm_i (imm_i),
    .result_o (result_o), .ea_o (ea_o), .mem_o (mem_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h (op %0d a %h b %h imm %h)",
               req, act, exp, op_i, rs1_i, rs2_i, imm_i);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm);
    @(negedge clk);
    op_i = op; rs1_i = a; rs2_i = b; imm_i = imm;
    #1;
  endtask

  function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] imm);
    logic [31:0] sx;
    sx = {{16{imm[15]}}, imm};
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a + sx;
      3'd3: return {imm, 16'h0};
      3'd4: return a << imm[4:0];
      3'd5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // idle inputs (all zero): add of zeros, no memory activity
    #1;
    check("R1 idle result", result_o, 32'h0);
    check("R8 idle ea", ea_o, 32'h0);
    check("R8 idle mem", {31'h0, mem_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].imm);
      check(tag(TBL[i].op), result_o, TBL[i].res);
      check((TBL[i].op >= 3'd6) ? "R7 ea" : "R8 ea", ea_o, TBL[i].ea);
      check((TBL[i].op >= 3'd6) ? "R7 mem" : "R8 mem", {31'h0, mem_o},
            {31'h0, TBL[i].op >= 3'd6});
    end

    // R4: operands must not leak into load-high
    apply(3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h8001);
    check("R4 operands ignored", result_o, 32'h80010000);

    // ADDI and load with same base/offset share one adder path
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, addi_res;
      logic [15:0] imm;
      a = $urandom(); imm = 16'($urandom());
      if (i == 0) begin a = 32'h0; imm = 16'hFFFF; end     // R9 absolute
      if (i == 1) begin a = 32'hFFFFFFFF; imm = 16'h0001; end
      apply(3'd2, a, 32'h0, imm);
      addi_res = result_o;
      check("R3 addi", addi_res, a + {{16{imm[15]}}, imm});
      apply(3'd6, a, 32'h0, imm);
      check("R7 ea equals addi", ea_o, addi_res);
      check("R7 load no writeback", result_o, 32'h0);
    end

    // random sweep against the reference model
    for (int i = 0; i < 800; i++) begin
      logic [2:0]  op;
      logic [31:0] a, b, exp_ea;
      logic [15:0] imm;
      op = 3'(i % 8); a = $urandom(); b = $urandom(); imm = 16'($urandom());
      if (i % 16 == 5) b = a;                       // R6 equal operands
      if (i % 32 == 13) begin a = 32'h80000000; b = 32'h7FFFFFFF; end
      apply(op, a, b, imm);
      exp_ea = (op >= 3'd6) ? a + {{16{imm[15]}}, imm} : 32'h0;
      check(tag(op), result_o, ref_res(op, a, b, imm));
      check((op >= 3'd6) ? "R7 ea" : "R8 ea", ea_o, exp_ea);
      check((op >= 3'd6) ? "R7 mem" : "R8 mem", {31'h0, mem_o}, {31'h0, op >= 3'd6});
    end

    finish_run();
  end
endmodule